// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Cell Array

This block is the output stage of a small programmable logic array. It holds ten output cells. Each cell builds its data from four AND terms and ORs them together. An AND term can take any mix of true and complemented input terms. The input terms are the dedicated array inputs plus the present value of every cell pin.

Each cell has one mode bit. It either drives its pin from that sum straight away (combinatorial) or from its own D flip-flop (registered). The flip-flop is not tied to a shared clock. It has separate product terms for its clock, its set and its reset. A fourth product term, gated by a global active-low enable, controls whether the pin is driven. A separate polarity bit can invert each pin.

The configuration arrives as one flat parallel vector and is held steady before operation. A preload control writes a supplied word into all the registers, so a test can start from any state. Everything is sampled on one fabric clock. The clock product term acts on its detected 0-to-1 transition.

Top module: `pal_array`

## Requirements
- R1: Term k (k below N_DED is dedicated input k, otherwise it is the feedback of cell k-N_DED) gives literal bit 2k in true form and literal bit 2k+1 in complement form. A product term is the AND of the literals whose mask bit is 1. An all-zero mask evaluates to 1, so a term is switched off by connecting both forms of one input.
- R2: Cell c takes the slice cfg_i[c*322 +: 322]. Product term p uses mask bits [p*40 +: 40], with p = 0..3 for data, 4 for clock, 5 for set, 6 for reset and 7 for enable. Bit 320 selects registered mode (1), and bit 321 inverts the pin. In combinatorial mode, pin_o shows (OR of the four data terms) XOR polarity one clock after the inputs are applied.
- R3: In registered mode, the flop loads the data sum on the first clock edge at which the clock term is 1 after having been 0 at the previous edge. pin_o shows the new value XOR polarity after that same edge.
- R4: When the set term is 1, the flop goes to 1 at the next edge. When the reset term is 1, it goes to 0. If both are 1, reset wins.
- R5: While preload_i is 1, each flop loads its bit of preload_val_i at the next edge. This overrides the set, reset and clock terms.
- R6: pin_oe_o[c] is 1 one clock after the enable term is 1 and oe_n_i is 0. Otherwise it is 0.
- R7: The feedback term of cell c is pin_o[c] when pin_oe_o[c] is 1 and pin_i[c] when it is 0. This lets registered cells build state machines.
- R8: A synchronous active-high rst clears every flop and every enable. pin_o then equals each cell's polarity bit.
- R9: With no preload, no set, no reset and no clock-term transition from 0 to 1, a registered cell keeps its value, even while the data sum changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 3220 | Flat configuration vector, 322 bits per cell |
| in_i | input | 10 | Dedicated array inputs |
| pin_i | input | 10 | Externally driven pin values, used while a pin is disabled |
| oe_n_i | input | 1 | Global active-low output enable |
| preload_i | input | 1 | Load preload_val_i into all registers |
| preload_val_i | input | 10 | Preload word, one bit per cell |
| pin_o | output | 10 | Pin drive values |
| pin_oe_o | output | 10 | Pin drive enables |

## Verification
The register's asynchronous controls can fall in the same cycle: set and reset, and preload together with an active reset term. The bench raises the set and reset inputs together and expects 0. It then holds both while raising preload with a 1 and expects 1 until preload drops, when the reset term pulls the value back to 0. A clock-term level held high while the data changes is also checked, to confirm that only a fresh 0-to-1 transition loads the register.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int N_DATA = 4;
  localparam int PT_CLK = 4;
  localparam int PT_SET = 5;
  localparam int PT_RST = 6;
  localparam int PT_OE  = 7;
  localparam int N_PT   = 8;

  function automatic int cell_width(input int n_terms);
    return N_PT * 2 * n_terms + 2;
  endfunction
endpackage

// File: rtl/pal_lits.sv
module pal_lits #(
  parameter int NT = 20
) (
  input  logic [NT-1:0]   terms_i,
  output logic [2*NT-1:0] lits_o
);
  for (genvar k = 0; k < NT; k++) begin : g_lit
    assign lits_o[2*k]   = terms_i[k];
    assign lits_o[2*k+1] = ~terms_i[k];
  end
endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int LW = 40
) (
  input  logic [LW-1:0] lits_i,
  input  logic [LW-1:0] mask_i,
  output logic          hit_o
);
  assign hit_o = &(lits_i | ~mask_i);
endmodule

// File: rtl/pal_cell.sv
module pal_cell
  import pal_pkg::*;
#(
  parameter int NT = 20,
  localparam int LW = 2 * NT,
  localparam int CW = N_PT * LW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] lits_i,
  input  logic [CW-1:0] cfg_i,
  input  logic          oe_n_i,
  input  logic          preload_i,
  input  logic          preload_bit_i,
  output logic          drv_o,
  output logic          en_o
);
  logic [N_PT-1:0] pt;
  logic data_sum, mode_reg, invert;
  logic q_r, comb_r, clk_d, en_r;

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    pal_pterm #(.LW(LW)) u_pt (
      .lits_i(lits_i),
      .mask_i(cfg_i[p*LW +: LW]),
      .hit_o (pt[p])
    );
  end

  assign data_sum = |pt[N_DATA-1:0];
  assign mode_reg = cfg_i[N_PT*LW];
  assign invert   = cfg_i[N_PT*LW+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r    <= 1'b0;
      comb_r <= 1'b0;
      clk_d  <= 1'b0;
      en_r   <= 1'b0;
    end else begin
      clk_d  <= pt[PT_CLK];
      comb_r <= data_sum;
      en_r   <= pt[PT_OE] & ~oe_n_i;
      if (preload_i)                   q_r <= preload_bit_i;
      else if (pt[PT_RST])             q_r <= 1'b0;
      else if (pt[PT_SET])             q_r <= 1'b1;
      else if (pt[PT_CLK] && !clk_d)   q_r <= data_sum;
    end
  end

  assign drv_o = (mode_reg ? q_r : comb_r) ^ invert;
  assign en_o  = en_r;

  p_rst_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (!preload_i && pt[PT_RST]) |=> !q_r);
  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    (!preload_i && !pt[PT_RST] && pt[PT_SET]) |=> q_r);
  p_preload_r5: assert property (@(posedge clk) disable iff (rst)
    preload_i |=> (q_r == $past(preload_bit_i)));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!preload_i && !pt[PT_RST] && !pt[PT_SET] && !(pt[PT_CLK] && !clk_d))
      |=> $stable(q_r));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!q_r && !en_r));
endmodule

// File: rtl/pal_array.sv
module pal_array
  import pal_pkg::*;
#(
  parameter int N_DED  = 10,
  parameter int N_CELL = 10,
  localparam int NT    = N_DED + N_CELL,
  localparam int CW    = N_PT * 2 * NT + 2,
  localparam int CFG_W = CW * N_CELL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic [N_DED-1:0]  in_i,
  input  logic [N_CELL-1:0] pin_i,
  input  logic              oe_n_i,
  input  logic              preload_i,
  input  logic [N_CELL-1:0] preload_val_i,
  output logic [N_CELL-1:0] pin_o,
  output logic [N_CELL-1:0] pin_oe_o
);
  logic [N_CELL-1:0] fb;
  logic [NT-1:0]     terms;
  logic [2*NT-1:0]   lits;

  assign fb    = (pin_oe_o & pin_o) | (~pin_oe_o & pin_i);
  assign terms = {fb, in_i};

  pal_lits #(.NT(NT)) u_lits (
    .terms_i(terms),
    .lits_o (lits)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    pal_cell #(.NT(NT)) u_cell (
      .clk          (clk),
      .rst          (rst),
      .lits_i       (lits),
      .cfg_i        (cfg_i[c*CW +: CW]),
      .oe_n_i       (oe_n_i),
      .preload_i    (preload_i),
      .preload_bit_i(preload_val_i[c]),
      .drv_o        (pin_o[c]),
      .en_o         (pin_oe_o[c])
    );
  end

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |=> (pin_oe_o == '0));
endmodule

// File: tb/sim_pal_array.sv
`timescale 1ns/1ps
module sim_pal_array;
  localparam int N_DED = 10, N_CELL = 10, NT = 20, LW = 40;
  localparam int CW = 8 * LW + 2, CFG_W = CW * N_CELL;
  localparam int NV = 6;
  // {in[4:0], expected pin[1:0]}
  localparam logic [6:0] VEC [NV] = '{7'b00000_11, 7'b00111_11, 7'b00101_10,
                                       7'b01100_00, 7'b11100_10, 7'b01011_01};

  logic clk = 1'b0, rst = 1'b1;
  logic [CFG_W-1:0] cfg = '0;
  logic [N_DED-1:0] in_v = '0;
  logic [N_CELL-1:0] pin_i = '0, pre_val = '0;
  logic oe_n = 1'b0, preload = 1'b0;
  logic [N_CELL-1:0] pin_o, pin_oe;
  int nchk = 0, nerr = 0;

  always #4 clk = ~clk;

  pal_array u0 (
    .clk(clk), .rst(rst), .cfg_i(cfg), .in_i(in_v), .pin_i(pin_i),
    .oe_n_i(oe_n), .preload_i(preload), .preload_val_i(pre_val),
    .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  task automatic conn(int c, int p, int l);
    cfg[c*CW + p*LW + l] = 1'b1;
  endtask
  task automatic kill(int c, int p);
    conn(c, p, 0); conn(c, p, 1);
  endtask
  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // cell0 comb: in0&in1 | ~in2
    conn(0, 0, 0); conn(0, 0, 2); conn(0, 1, 5); kill(0, 2); kill(0, 3);
    // cell1 comb inverted: ~(in3 & ~in4)
    conn(1, 0, 6); conn(1, 0, 9); kill(1, 1); kill(1, 2); kill(1, 3);
    cfg[1*CW + 8*LW + 1] = 1'b1;
    // cell2 registered: d=in5 clk=in6 set=in7 rst=in8 oe=in9
    conn(2, 0, 10); kill(2, 1); kill(2, 2); kill(2, 3);
    conn(2, 4, 12); conn(2, 5, 14); conn(2, 6, 16); conn(2, 7, 18);
    cfg[2*CW + 8*LW] = 1'b1;
    // cell3 comb: feedback of cell2 (term 12, literal 24)
    conn(3, 0, 24); kill(3, 1); kill(3, 2); kill(3, 3);
    // cell4 registered toggle: d=~pin4 (literal 29), clk=in6
    conn(4, 0, 29); kill(4, 1); kill(4, 2); kill(4, 3);
    conn(4, 4, 12); kill(4, 5); kill(4, 6);
    cfg[4*CW + 8*LW] = 1'b1;

    tick(3);
    chk("R8 reset pin_o", pin_o, 10'h002);
    chk("R8 reset pin_oe", pin_oe, 10'h000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_v[4:0] = VEC[i][6:2];
      tick(1);
      chk("R2 comb vector", pin_o[1:0], VEC[i][1:0]);
      chk("R1 empty enable mask", pin_oe[1:0], 2'b11);
    end
    in_v = '0;

    in_v[9] = 1'b1; tick(1);
    chk("R6 enable term", pin_oe[2], 1'b1);
    oe_n = 1'b1; tick(1);
    chk("R6 global disable", pin_oe, 10'h000);
    oe_n = 1'b0; tick(1);

    in_v[5] = 1'b1; in_v[6] = 1'b0; tick(1);
    in_v[6] = 1'b1; tick(1);
    chk("R3 capture 1", pin_o[2], 1'b1);
    in_v[5] = 1'b0; tick(2);
    chk("R9 clock held high", pin_o[2], 1'b1);
    in_v[6] = 1'b0; tick(1);
    chk("R9 clock fall", pin_o[2], 1'b1);
    in_v[6] = 1'b1; tick(1);
    chk("R3 capture 0", pin_o[2], 1'b0);

    in_v[7] = 1'b1; tick(1);
    chk("R4 set", pin_o[2], 1'b1);
    in_v[7] = 1'b0; tick(1);
    chk("R9 hold after set", pin_o[2], 1'b1);
    in_v[7] = 1'b1; in_v[8] = 1'b1; tick(1);
    chk("R4 reset wins", pin_o[2], 1'b0);
    preload = 1'b1; pre_val = 10'h004; tick(1);
    chk("R5 preload over reset", pin_o[2], 1'b1);
    chk("R5 preload zero", pin_o[4], 1'b0);
    preload = 1'b0; tick(1);
    chk("R4 reset after preload", pin_o[2], 1'b0);
    in_v[7] = 1'b0; in_v[8] = 1'b0; tick(1);

    in_v[7] = 1'b1; tick(1); in_v[7] = 1'b0; tick(2);
    chk("R7 enabled feedback", pin_o[3], 1'b1);
    in_v[9] = 1'b0; pin_i[2] = 1'b0; tick(3);
    chk("R7 external pin 0", pin_o[3], 1'b0);
    pin_i[2] = 1'b1; tick(2);
    chk("R7 external pin 1", pin_o[3], 1'b1);

    in_v[6] = 1'b0; tick(2);
    in_v[6] = 1'b1; tick(1);
    chk("R7 toggle 1", pin_o[4], 1'b1);
    in_v[6] = 1'b0; tick(2); in_v[6] = 1'b1; tick(1);
    chk("R7 toggle 2", pin_o[4], 1'b0);
    in_v[6] = 1'b0; tick(2); in_v[6] = 1'b1; tick(1);
    chk("R7 toggle 3", pin_o[4], 1'b1);

    rst = 1'b1; tick(1);
    chk("R8 late reset pin_o", pin_o, 10'h002);
    chk("R8 late reset pin_oe", pin_oe, 10'h000);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule